// File: doc/BRIEF.md
# Mode-Dependent Flash Bus Responder

This block is the slave-side front end of an on-chip flash array. Each bus request carries a word address, a direction and write data. The block decides from the chip operating mode whether to answer that request, answer it with an error, or leave it alone. It also checks whether the address falls inside the array window and whether the request is the first one since reset. It drives a one-cycle transfer-acknowledge or transfer-error pulse on the cycle after the request. The array itself is modelled as a plain synchronous word memory.

A small control register sits beside the array. It holds a 7-bit clock-divider field, a lock bit that freezes that field, and a sticky access-error flag. Whether a write to the lock and divider takes effect depends on the lock state and on whether the chip is in debug mode. Program and erase sequencing, the external memory used in emulation, and bus arbitration are handled elsewhere.

Top module: `flash_bus_resp`

## Requirements
- R1: With `mode_i` = 2'b00 (user), a request whose word address lies in [BASE, BASE+WORDS-1] gets `ack_o` high for exactly the following cycle. A read returns the stored word on `rdata_o` in that same cycle, and a write stores `wdata_i` at that word.
- R2: A request whose address lies outside [BASE, BASE+WORDS-1] never raises `ack_o` or `err_o`, in any mode.
- R3: With `mode_i` = 2'b01 (master) and `ext_boot_i` high, the first request after reset gets neither `ack_o` nor `err_o`, even when it hits the array. That first request clears the suppression whether or not it hit, and later hits are acknowledged as in R1.
- R4: The first-request suppression applies only in master mode with `ext_boot_i` high. In master mode with `ext_boot_i` low, the first hit after reset is acknowledged normally.
- R5: With `mode_i` = 2'b10 (emulation), a read that hits the array gets neither `ack_o` nor `err_o`.
- R6: In emulation mode, a write that hits the array raises `err_o` for the following cycle and does not change the stored word. It also sets the access-error flag, `cfg_o[8]`, in that same cycle.
- R7: The access-error flag `cfg_o[8]` is 0 after reset. A control-register write with bit 8 set clears it, in any mode and whatever the lock state.
- R8: The control register holds the clock divider in `cfg_o[6:0]` and the lock bit in `cfg_o[7]`. While unlocked, a write with `cfg_wr_i` high loads both from `cfg_wdata_i[7:0]` on the next clock edge.
- R9: Outside debug mode, once `cfg_o[7]` is 1, writes leave `cfg_o[7:0]` unchanged until the next reset.
- R10: With `mode_i` = 2'b11 (debug), the lock bit and the divider are always writable, including clearing a set lock. Array behaviour in debug mode is the same as in user mode.
- R11: During and right after reset, `ack_o` and `err_o` are low and `cfg_o` is 0.
- R12: `ack_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Operating mode: 00 user, 01 master, 10 emulation, 11 debug |
| ext_boot_i | input | 1 | High when an external device is the boot source |
| req_i | input | 1 | Bus transfer request, one cycle per transfer |
| wr_i | input | 1 | Direction of the request: 1 write, 0 read |
| addr_i | input | AW | Word address of the request |
| wdata_i | input | DW | Write data for array writes |
| rdata_o | output | DW | Read data, valid while `ack_o` answers a read |
| ack_o | output | 1 | Transfer acknowledge, one-cycle pulse |
| err_o | output | 1 | Transfer error, one-cycle pulse |
| cfg_wr_i | input | 1 | Control-register write strobe |
| cfg_wdata_i | input | 9 | Control-register write data: [6:0] divider, [7] lock, [8] write 1 to clear the error flag |
| cfg_o | output | 9 | Control-register contents: [6:0] divider, [7] lock, [8] access-error flag |

## Verification
The bench builds the block with AW = 12, BASE = 12'h040 and WORDS = 16. With these values the lowest and highest array words (0x040 and 0x04F) and both neighbours just outside the window (0x03F and 0x050) can be reached with a handful of literal addresses. The bench repeats reset in master mode with the boot-source input both high and low. This lets it reach the first-request rule with a hit, with a miss, and with suppression disabled, while array contents carry over from earlier tests to show that blocked writes left them alone.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [1:0] {
    MODE_USER   = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_EMUL   = 2'b10,
    MODE_DEBUG  = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_ACK  = 2'b01,
    RSP_ERR  = 2'b10
  } rsp_e;

  localparam int DIV_W      = 7;
  localparam int LOCK_POS   = 7;
  localparam int ACCERR_POS = 8;
  localparam int CFG_W      = 9;

endpackage

// File: rtl/fbr_rst_sync.sv
module fbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fbr_decode.sv
module fbr_decode
  import fbr_pkg::*;
#(
  parameter int          AW    = 12,
  parameter int          WORDS = 16,
  parameter logic [AW-1:0] BASE = 12'h040,
  localparam int         IDX_W = $clog2(WORDS)
) (
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  op_mode_e         mode_i,
  input  logic             ext_boot_i,
  input  logic             first_i,
  output rsp_e             rsp_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [AW:0] END_EXCL = {1'b0, BASE} + (AW+1)'(WORDS);

  logic          hit;
  logic          suppress;
  logic [AW-1:0] offset;

  always_comb begin
    hit      = (addr_i >= BASE) && ({1'b0, addr_i} < END_EXCL);
    suppress = first_i && (mode_i == MODE_MASTER) && ext_boot_i;
    offset   = addr_i - BASE;
    idx_o    = offset[IDX_W-1:0];
    rsp_o    = RSP_NONE;
    mem_we_o = 1'b0;
    mem_re_o = 1'b0;
    if (req_i && hit && !suppress) begin
      if (mode_i == MODE_EMUL) begin
        if (wr_i) rsp_o = RSP_ERR;
      end else begin
        rsp_o    = RSP_ACK;
        mem_we_o = wr_i;
        mem_re_o = !wr_i;
      end
    end
  end
endmodule

// File: rtl/fbr_ctrl_reg.sv
module fbr_ctrl_reg
  import fbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  op_mode_e         mode_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             accerr_set_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic             lock_q, lock_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             accerr_q, accerr_d;
  logic             field_en, accerr_en;

  always_comb begin
    field_en  = cfg_wr_i && (!lock_q || (mode_i == MODE_DEBUG));
    lock_d    = cfg_wdata_i[LOCK_POS];
    div_d     = cfg_wdata_i[DIV_W-1:0];
    accerr_en = accerr_set_i || (cfg_wr_i && cfg_wdata_i[ACCERR_POS]);
    accerr_d  = accerr_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      div_q  <= '0;
    end else if (field_en) begin
      lock_q <= lock_d;
      div_q  <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         accerr_q <= 1'b0;
    else if (accerr_en) accerr_q <= accerr_d;
  end

  assign cfg_o = {accerr_q, lock_q, div_q};
endmodule

// File: rtl/fbr_array.sv
module fbr_array #(
  parameter int DW    = 32,
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= mem_q[idx_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_bus_resp.sv
module flash_bus_resp
  import fbr_pkg::*;
#(
  parameter int            AW    = 12,
  parameter int            DW    = 32,
  parameter int            WORDS = 16,
  parameter logic [AW-1:0] BASE  = 12'h040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             ext_boot_i,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             ack_o,
  output logic             err_o,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int IDX_W = $clog2(WORDS);

  logic             rst_sync_n;
  op_mode_e         mode;
  rsp_e             rsp;
  logic             mem_we, mem_re;
  logic [IDX_W-1:0] idx;
  logic             first_q;
  logic             ack_q, ack_d;
  logic             err_q, err_d;

  assign mode = op_mode_e'(mode_i);

  fbr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fbr_decode #(.AW(AW), .WORDS(WORDS), .BASE(BASE)) decode_i (
    .req_i      (req_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .mode_i     (mode),
    .ext_boot_i (ext_boot_i),
    .first_i    (first_q),
    .rsp_o      (rsp),
    .mem_we_o   (mem_we),
    .mem_re_o   (mem_re),
    .idx_o      (idx)
  );

  fbr_array #(.DW(DW), .WORDS(WORDS)) array_i (
    .clk     (clk),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  fbr_ctrl_reg ctrl_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode_i       (mode),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .accerr_set_i (err_d),
    .cfg_o        (cfg_o)
  );

  always_comb begin
    ack_d = (rsp == RSP_ACK);
    err_d = (rsp == RSP_ERR);
  end

  // first-request flag: set by reset, cleared by any request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  first_q <= 1'b1;
    else if (req_i)   first_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      err_q <= err_d;
    end
  end

  assign ack_o = ack_q;
  assign err_o = err_q;
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int            AW    = 12,
  parameter int            WORDS = 16,
  parameter logic [AW-1:0] BASE  = 12'h040
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic          ext_boot_i,
  input logic          req_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic          ack_o,
  input logic          err_o,
  input logic [8:0]    cfg_o
);
  localparam logic [AW:0] END_EXCL = {1'b0, BASE} + (AW+1)'(WORDS);

  logic in_win;
  logic seen_q;

  assign in_win = (addr_i >= BASE) && ({1'b0, addr_i} < END_EXCL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= 1'b0;
    else if (req_i) seen_q <= 1'b1;
  end

  AST_USER_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && in_win && mode_i == 2'b00) |=> (ack_o && !err_o)); // R1

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !in_win) |=> (!ack_o && !err_o)); // R2

  AST_BOOT_FIRST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !seen_q && mode_i == 2'b01 && ext_boot_i) |=> (!ack_o && !err_o)); // R3

  AST_EMUL_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && mode_i == 2'b10) |=> (!ack_o && !err_o)); // R5

  AST_EMUL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wr_i && in_win && mode_i == 2'b10) |=> (err_o && cfg_o[8])); // R6

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[7] && mode_i != 2'b11) |=> (cfg_o[7] && $stable(cfg_o[6:0]))); // R9

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && err_o)); // R12
endmodule

bind flash_bus_resp fbr_checker #(.AW(AW), .WORDS(WORDS), .BASE(BASE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mode_i     (mode_i),
  .ext_boot_i (ext_boot_i),
  .req_i      (req_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .ack_o      (ack_o),
  .err_o      (err_o),
  .cfg_o      (cfg_o)
);

// File: tb/flash_bus_resp_tb_top.sv
module flash_bus_resp_tb_top;
  localparam int            AW    = 12;
  localparam int            DW    = 32;
  localparam int            WORDS = 16;
  localparam logic [AW-1:0] BASE  = 12'h040;

  typedef struct {
    int          due;
    logic        ack;
    logic        err;
    logic        rd;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          ext_boot_i = 1'b0;
  logic          req_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          ack_o, err_o;
  logic          cfg_wr_i = 1'b0;
  logic [8:0]    cfg_wdata_i = '0;
  logic [8:0]    cfg_o;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_bus_resp #(.AW(AW), .DW(DW), .WORDS(WORDS), .BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ext_boot_i(ext_boot_i),
    .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ack_o(ack_o), .err_o(err_o),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_o(cfg_o)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses when they fall due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t it;
      it = sb.pop_front();
      check_eq({it.tag, " ack"}, {31'd0, ack_o}, {31'd0, it.ack});
      check_eq({it.tag, " err"}, {31'd0, err_o}, {31'd0, it.err});
      check_eq("R12 ack/err exclusive", {31'd0, ack_o && err_o}, 32'd0);
      if (it.ack && it.rd) check_eq({it.tag, " rdata"}, rdata_o, it.data);
    end
  end

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic e_ack, input logic e_err, input string tag);
    exp_t it;
    @(negedge clk);
    req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
    it.due = cyc + 1; it.ack = e_ack; it.err = e_err; it.rd = !w; it.data = d; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    req_i = 1'b0; wr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [8:0] d, input logic [8:0] e, input string tag);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    check_eq(tag, {23'd0, cfg_o}, {23'd0, e});
  endtask

  task automatic do_reset(input logic [1:0] m, input logic eb);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; ext_boot_i = eb;
    repeat (3) @(negedge clk);
    check_eq("R11 ack in reset", {31'd0, ack_o}, 32'd0);
    check_eq("R11 cfg in reset", {23'd0, cfg_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset(2'b00, 1'b0);
    check_eq("R11 err after reset", {31'd0, err_o}, 32'd0);
    check_eq("R7 accerr after reset", {31'd0, cfg_o[8]}, 32'd0);

    // user mode array traffic
    xfer(1'b1, 12'h043, 32'hA5A5_1234, 1'b1, 1'b0, "R1 user write");
    xfer(1'b0, 12'h043, 32'hA5A5_1234, 1'b1, 1'b0, "R1 user read");
    xfer(1'b1, 12'h040, 32'h0000_0F0F, 1'b1, 1'b0, "R1 write first word");
    xfer(1'b1, 12'h04F, 32'hDEAD_BEEF, 1'b1, 1'b0, "R1 write last word");
    xfer(1'b0, 12'h04F, 32'hDEAD_BEEF, 1'b1, 1'b0, "R1 read last word");
    xfer(1'b0, 12'h040, 32'h0000_0F0F, 1'b1, 1'b0, "R1 read first word");
    xfer(1'b0, 12'h03F, 32'h0, 1'b0, 1'b0, "R2 read below window");
    xfer(1'b1, 12'h050, 32'h1, 1'b0, 1'b0, "R2 write above window");

    // control register
    cfg_write(9'h02A, 9'h02A, "R8 unlocked divider write");
    cfg_write(9'h095, 9'h095, "R8 set lock and divider");
    cfg_write(9'h000, 9'h095, "R9 locked write ignored in user");

    // emulation mode
    mode_i = 2'b10;
    xfer(1'b0, 12'h043, 32'h0, 1'b0, 1'b0, "R5 emulation read no response");
    xfer(1'b1, 12'h043, 32'h1111_1111, 1'b0, 1'b1, "R6 emulation write error");
    check_eq("R6 accerr set", {23'd0, cfg_o}, 32'h195);
    xfer(1'b1, 12'h060, 32'h2, 1'b0, 1'b0, "R2 emulation miss silent");
    cfg_write(9'h07F, 9'h195, "R9 locked write ignored in emulation");
    mode_i = 2'b00;
    xfer(1'b0, 12'h043, 32'hA5A5_1234, 1'b1, 1'b0, "R6 array unchanged by emulation write");
    cfg_write(9'h100, 9'h095, "R7 write-one clears accerr under lock");

    // debug mode
    mode_i = 2'b11;
    cfg_write(9'h003, 9'h003, "R10 debug clears lock and loads divider");
    cfg_write(9'h0C4, 9'h0C4, "R10 debug sets lock");
    cfg_write(9'h011, 9'h011, "R10 debug writes through lock");
    xfer(1'b0, 12'h04F, 32'hDEAD_BEEF, 1'b1, 1'b0, "R10 debug read like user");

    // master mode, external boot: first hit ignored
    do_reset(2'b01, 1'b1);
    check_eq("R9 lock released by reset", {23'd0, cfg_o}, 32'h0);
    xfer(1'b0, 12'h043, 32'hA5A5_1234, 1'b0, 1'b0, "R3 first hit ignored");
    xfer(1'b0, 12'h043, 32'hA5A5_1234, 1'b1, 1'b0, "R3 second hit answered");

    // master, external boot: first request misses, next hit answered
    do_reset(2'b01, 1'b1);
    xfer(1'b0, 12'h010, 32'h0, 1'b0, 1'b0, "R3 first request miss");
    xfer(1'b0, 12'h04F, 32'hDEAD_BEEF, 1'b1, 1'b0, "R3 flag cleared by miss");

    // master without external boot: first hit answered
    do_reset(2'b01, 1'b0);
    xfer(1'b0, 12'h040, 32'h0000_0F0F, 1'b1, 1'b0, "R4 first hit answered without ext boot");

    // user mode after reset: first hit answered
    do_reset(2'b00, 1'b1);
    xfer(1'b0, 12'h043, 32'hA5A5_1234, 1'b1, 1'b0, "R4 user first hit answered");

    repeat (3) @(negedge clk);
    check_eq("scoreboard drained", sb.size(), 32'd0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule